// File: doc/BRIEF.md
# Row-Streaming Operand Gather Sequencer

This block feeds a pipelined field-update datapath from five parallel 32-bit memory read lanes. It walks a straight row of mesh cells whose operands sit at consecutive memory addresses, one cell after another. Each cell's eight operands (current value a, neighbour fields b, c, d, e, coefficients k1 and k2, source js) arrive in two read beats. The first beat is parked in staging registers. When the second beat arrives, the whole operand set goes to the datapath in one cycle.

Each row starts at a base address plus a multiple of a row pitch. Row length and row count are taken at start, so the scan can follow the longest edge of the mesh. Within a row, reads follow one another without a gap. Between rows a fixed bubble of `N_ROWGAP` cycles is inserted. Each issued cell's address goes into a small in-order queue. When the datapath returns a result, the block writes it straight back to that cell's address in the same cycle.

Top module: `rowscan_gather`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `rd_req`, `iss_valid` and `done` all low.
- R2: A `start` pulse is ignored when `n_rows` or `row_len` is zero, and when a scan is already running. An ignored pulse produces no read request, no issue and no `done`, and does not disturb a running scan.
- R3: For cell (r, c), counted from zero, both read beats use address `base_addr + r*row_pitch + c`, with `rd_beat` = 0 first and then 1. Address and beat are held while `rd_req` waits for `rd_valid`.
- R4: One cycle after a beat-1 read is accepted, `iss_valid` is high for one cycle. The operands are taken by lane, where lane L is `rd_data[32L+31:32L]`: beat 0 lanes 0..4 give a, b, c, d, e, and beat 1 lanes 0..2 give k1, k2, js. Beat-1 lanes 3 and 4 have no effect.
- R5: Beat-0 words are held unchanged in staging however many cycles `rd_valid` is withheld before beat 1.
- R6: Inside a row, `rd_req` is high in the cycle right after each beat-1 acceptance.
- R7: After the last cell of a row that is not the final row, `rd_req` is low for exactly `N_ROWGAP` cycles before the next row's first read.
- R8: `wr_en` equals `res_valid` in the same cycle, and `wr_data` equals `res_data`. `wr_addr` is the address of the oldest issued cell not yet written back, so results retire in issue order.
- R9: `done` is high for exactly one cycle, together with the `iss_valid` of the final cell. After that no further read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan with the current configuration |
| n_rows | input | NROW_W | Number of rows to scan |
| row_len | input | ROW_W | Cells per row |
| base_addr | input | ADDR_W | Address of cell (0,0) |
| row_pitch | input | ADDR_W | Address step between row starts |
| rd_req | output | 1 | Read beat requested |
| rd_beat | output | 1 | Which beat (0 or 1) is requested |
| rd_addr | output | ADDR_W | Cell address for the requested beat |
| rd_valid | input | 1 | Read data for the requested beat present |
| rd_data | input | N_LANES*32 | Parallel lane data, lane L at bits 32L+31:32L |
| iss_valid | output | 1 | Operand set valid for the datapath |
| iss_a | output | 32 | Current field value |
| iss_b | output | 32 | First neighbour field |
| iss_c | output | 32 | Second neighbour field |
| iss_d | output | 32 | Third neighbour field |
| iss_e | output | 32 | Fourth neighbour field |
| iss_k1 | output | 32 | First material coefficient |
| iss_k2 | output | 32 | Second material coefficient |
| iss_js | output | 32 | Source term |
| res_valid | input | 1 | Datapath result present |
| res_data | input | 32 | Datapath result word |
| wr_en | output | 1 | Write-back strobe |
| wr_addr | output | ADDR_W | Write-back address |
| wr_data | output | 32 | Write-back word |
| done | output | 1 | Final cell issued |

## Verification
The operand set and `done` are due one cycle after the edge that accepts beat 1. The next read request is due in the cycle right after that acceptance within a row, and `N_ROWGAP` cycles later at a row change. The write port follows `res_valid` in the same cycle, with no register in between. The bench drives and samples on the falling edge. It sets the next read response and result at that point, and checks the issued operands against the response it gave on the previous falling edge. It checks the write port one time unit after driving `res_valid`. The row gap is measured by counting request-low falling edges from the last acceptance of a row.

// File: rtl/rsg_pkg.sv
// Shared constants and types for the row-streaming operand gather sequencer.
// Assumes a 32-bit operand word and at least five read lanes.
package rsg_pkg;

    localparam int WORD_W    = 32;
    localparam int MIN_LANES = 5;

    // Beat 0 lane assignment
    localparam int LANE_A  = 0;
    localparam int LANE_B  = 1;
    localparam int LANE_C  = 2;
    localparam int LANE_D  = 3;
    localparam int LANE_E  = 4;
    // Beat 1 lane assignment (remaining lanes unused)
    localparam int LANE_K1 = 0;
    localparam int LANE_K2 = 1;
    localparam int LANE_JS = 2;

    typedef enum logic [1:0] {
        SCAN_IDLE,
        SCAN_BEAT0,
        SCAN_BEAT1,
        SCAN_GAP
    } scan_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] c;
        logic [WORD_W-1:0] d;
        logic [WORD_W-1:0] e;
        logic [WORD_W-1:0] k1;
        logic [WORD_W-1:0] k2;
        logic [WORD_W-1:0] js;
    } opset_t;

endpackage

// File: rtl/rsg_scan_ctrl.sv
// Scan controller: walks n_rows rows of row_len cells, asks for two read
// beats per cell and inserts N_ROWGAP idle cycles between rows.
// Assumes the read side holds rd_valid only in response to rd_req.
module rsg_scan_ctrl
    import rsg_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int ROW_W    = 12,
    parameter int NROW_W   = 12,
    parameter int N_ROWGAP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NROW_W-1:0] n_rows,
    input  logic [ROW_W-1:0]  row_len,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] row_pitch,
    input  logic              rd_valid,
    output logic              rd_req,
    output logic              rd_beat,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              beat0_acc,
    output logic              beat1_acc,
    output logic              last_cell
);

    localparam int GAP_W = (N_ROWGAP > 1) ? $clog2(N_ROWGAP) : 1;
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'((N_ROWGAP > 0) ? N_ROWGAP - 1 : 0);

    scan_state_t       state_q, state_d;
    logic [ROW_W-1:0]  col_q;
    logic [ROW_W-1:0]  len_q;
    logic [NROW_W-1:0] row_q;
    logic [NROW_W-1:0] rows_q;
    logic [ADDR_W-1:0] pitch_q;
    logic [ADDR_W-1:0] row_base_q;
    logic              start_ok;
    logic              col_end;
    logic              row_end;
    logic              enter_gap;
    logic              gap_done;

    // Qualify a start request: idle and both counts non-zero
    always_comb begin
        start_ok = start && (state_q == SCAN_IDLE) && (n_rows != '0) && (row_len != '0);
    end

    // Position flags and acceptance strobes
    always_comb begin
        col_end   = (col_q == len_q - ROW_W'(1));
        row_end   = (row_q == rows_q - NROW_W'(1));
        rd_req    = (state_q == SCAN_BEAT0) || (state_q == SCAN_BEAT1);
        rd_beat   = (state_q == SCAN_BEAT1);
        rd_addr   = row_base_q + ADDR_W'(col_q);
        beat0_acc = (state_q == SCAN_BEAT0) && rd_valid;
        beat1_acc = (state_q == SCAN_BEAT1) && rd_valid;
        last_cell = beat1_acc && col_end && row_end;
        enter_gap = beat1_acc && col_end && !row_end && (N_ROWGAP > 0);
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_IDLE:  if (start_ok) state_d = SCAN_BEAT0;
            SCAN_BEAT0: if (rd_valid) state_d = SCAN_BEAT1;
            SCAN_BEAT1: begin
                if (rd_valid) begin
                    if (!col_end)      state_d = SCAN_BEAT0;
                    else if (row_end)  state_d = SCAN_IDLE;
                    else if (N_ROWGAP > 0) state_d = SCAN_GAP;
                    else               state_d = SCAN_BEAT0;
                end
            end
            SCAN_GAP:   if (gap_done) state_d = SCAN_BEAT0;
            default:    state_d = SCAN_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCAN_IDLE;
        else        state_q <= state_d;
    end

    // Configuration latch, taken only on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            rows_q  <= '0;
            pitch_q <= '0;
        end else if (start_ok) begin
            len_q   <= row_len;
            rows_q  <= n_rows;
            pitch_q <= row_pitch;
        end
    end

    // Column, row and row-base address counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q      <= '0;
            row_q      <= '0;
            row_base_q <= '0;
        end else if (start_ok) begin
            col_q      <= '0;
            row_q      <= '0;
            row_base_q <= base_addr;
        end else if (beat1_acc) begin
            if (col_end) begin
                col_q      <= '0;
                row_q      <= row_q + NROW_W'(1);
                row_base_q <= row_base_q + pitch_q;
            end else begin
                col_q <= col_q + ROW_W'(1);
            end
        end
    end

    // Row-change bubble counter, present only when a gap is configured
    generate
        if (N_ROWGAP > 0) begin : g_gap
            logic [GAP_W-1:0] gap_q;
            // Load on row change, count down while in the gap
            always_ff @(posedge clk) begin
                if (!rst_n)                                  gap_q <= '0;
                else if (enter_gap)                          gap_q <= GAP_LOAD;
                else if (state_q == SCAN_GAP && gap_q != '0) gap_q <= gap_q - GAP_W'(1);
            end
            assign gap_done = (gap_q == '0);
        end else begin : g_nogap
            assign gap_done = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/rsg_stage.sv
// Operand staging: captures beat-0 lanes, then issues the full operand set
// one cycle after beat 1 is accepted. Assumes N_LANES >= MIN_LANES.
module rsg_stage
    import rsg_pkg::*;
#(
    parameter int N_LANES = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      beat0_acc,
    input  logic                      beat1_acc,
    input  logic                      last_cell,
    input  logic [N_LANES*WORD_W-1:0] rd_data,
    output logic                      iss_valid,
    output opset_t                    iss_ops,
    output logic                      done
);

    logic [WORD_W-1:0] lane_w [N_LANES];
    logic [WORD_W-1:0] hold_q [MIN_LANES];

    // Split the flat read bus into lane words
    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            assign lane_w[g] = rd_data[g*WORD_W +: WORD_W];
        end
    endgenerate

    // Staging registers for the first beat
    generate
        for (genvar h = 0; h < MIN_LANES; h++) begin : g_hold
            // Capture lane h when beat 0 is accepted
            always_ff @(posedge clk) begin
                if (!rst_n)         hold_q[h] <= '0;
                else if (beat0_acc) hold_q[h] <= lane_w[h];
            end
        end
    endgenerate

    // Issue register: merge staged beat 0 with live beat 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_ops <= '0;
        end else if (beat1_acc) begin
            iss_ops.a  <= hold_q[LANE_A];
            iss_ops.b  <= hold_q[LANE_B];
            iss_ops.c  <= hold_q[LANE_C];
            iss_ops.d  <= hold_q[LANE_D];
            iss_ops.e  <= hold_q[LANE_E];
            iss_ops.k1 <= lane_w[LANE_K1];
            iss_ops.k2 <= lane_w[LANE_K2];
            iss_ops.js <= lane_w[LANE_JS];
        end
    end

    // Issue and completion strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            iss_valid <= beat1_acc;
            done      <= last_cell;
        end
    end

endmodule

// File: rtl/rsg_wb_fifo.sv
// In-order queue of write-back addresses, one entry per issued cell.
// Assumes DEPTH covers the datapath latency so it never overflows.
module rsg_wb_fifo #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;

    // Present the oldest entry
    always_comb begin
        head_addr = mem_q[rd_ptr_q];
    end

    // Storage write on push
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (push) begin
            mem_q[wr_ptr_q] <= push_addr;
        end
    end

    // Pointer advance with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + PTR_W'(1);
            if (pop)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + PTR_W'(1);
        end
    end

endmodule

// File: rtl/rowscan_gather.sv
// Top: row-streaming operand gather sequencer. Scans rows of cells, gathers
// eight operands per cell over two beats of parallel lanes, issues them
// together and writes each datapath result back to its cell's address.
// Assumes the datapath returns results in issue order within PIPE_LAT.
module rowscan_gather
    import rsg_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int ROW_W    = 12,
    parameter int NROW_W   = 12,
    parameter int N_LANES  = 5,
    parameter int N_ROWGAP = 2,
    parameter int PIPE_LAT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NROW_W-1:0]         n_rows,
    input  logic [ROW_W-1:0]          row_len,
    input  logic [ADDR_W-1:0]         base_addr,
    input  logic [ADDR_W-1:0]         row_pitch,
    output logic                      rd_req,
    output logic                      rd_beat,
    output logic [ADDR_W-1:0]         rd_addr,
    input  logic                      rd_valid,
    input  logic [N_LANES*WORD_W-1:0] rd_data,
    output logic                      iss_valid,
    output logic [WORD_W-1:0]         iss_a,
    output logic [WORD_W-1:0]         iss_b,
    output logic [WORD_W-1:0]         iss_c,
    output logic [WORD_W-1:0]         iss_d,
    output logic [WORD_W-1:0]         iss_e,
    output logic [WORD_W-1:0]         iss_k1,
    output logic [WORD_W-1:0]         iss_k2,
    output logic [WORD_W-1:0]         iss_js,
    input  logic                      res_valid,
    input  logic [WORD_W-1:0]         res_data,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [WORD_W-1:0]         wr_data,
    output logic                      done
);

    logic              beat0_acc;
    logic              beat1_acc;
    logic              last_cell;
    logic [ADDR_W-1:0] iss_addr_q;
    opset_t            ops;

    rsg_scan_ctrl #(
        .ADDR_W   (ADDR_W),
        .ROW_W    (ROW_W),
        .NROW_W   (NROW_W),
        .N_ROWGAP (N_ROWGAP)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .n_rows    (n_rows),
        .row_len   (row_len),
        .base_addr (base_addr),
        .row_pitch (row_pitch),
        .rd_valid  (rd_valid),
        .rd_req    (rd_req),
        .rd_beat   (rd_beat),
        .rd_addr   (rd_addr),
        .beat0_acc (beat0_acc),
        .beat1_acc (beat1_acc),
        .last_cell (last_cell)
    );

    rsg_stage #(
        .N_LANES (N_LANES)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat0_acc (beat0_acc),
        .beat1_acc (beat1_acc),
        .last_cell (last_cell),
        .rd_data   (rd_data),
        .iss_valid (iss_valid),
        .iss_ops   (ops),
        .done      (done)
    );

    // Cell address travelling alongside the issue register
    always_ff @(posedge clk) begin
        if (!rst_n)         iss_addr_q <= '0;
        else if (beat1_acc) iss_addr_q <= rd_addr;
    end

    rsg_wb_fifo #(
        .DEPTH  (PIPE_LAT),
        .ADDR_W (ADDR_W)
    ) u_wbq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (iss_valid),
        .push_addr (iss_addr_q),
        .pop       (res_valid),
        .head_addr (wr_addr)
    );

    // Operand fan-out and unbuffered write-back
    always_comb begin
        iss_a   = ops.a;
        iss_b   = ops.b;
        iss_c   = ops.c;
        iss_d   = ops.d;
        iss_e   = ops.e;
        iss_k1  = ops.k1;
        iss_k2  = ops.k2;
        iss_js  = ops.js;
        wr_en   = res_valid;
        wr_data = res_data;
    end

endmodule

// File: rtl/rowscan_gather_chk.sv
// Protocol checker for rowscan_gather, attached with bind.
module rowscan_gather_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_beat,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic              iss_valid,
    input logic              res_valid,
    input logic              done
);

    logic [7:0] outstanding_q;

    // Track issued cells whose results are still pending
    always_ff @(posedge clk) begin
        if (!rst_n) outstanding_q <= '0;
        else        outstanding_q <= outstanding_q + 8'(iss_valid) - 8'(res_valid);
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!rd_req && !iss_valid && !done));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr) && $stable(rd_beat)));

    p_beat_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid && !rd_beat) |=> (rd_req && rd_beat && $stable(rd_addr)));

    p_issue_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid && rd_beat) |=> iss_valid);

    p_issue_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> $past(rd_req && rd_valid && rd_beat));

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (outstanding_q != '0 || iss_valid));

    p_done_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (iss_valid && !rd_req));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind rowscan_gather rowscan_gather_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_beat   (rd_beat),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .iss_valid (iss_valid),
    .res_valid (res_valid),
    .done      (done)
);

// File: tb/rowscan_gather_tb.sv
module rowscan_gather_tb;

    localparam int ADDR_W   = 24;
    localparam int ROW_W    = 8;
    localparam int NROW_W   = 6;
    localparam int N_LANES  = 5;
    localparam int N_ROWGAP = 3;
    localparam int PIPE_LAT = 4;
    localparam int W        = 32;

    // Scan vectors: rows, cells per row, base, pitch, rd_valid delay per beat
    localparam int NV = 4;
    localparam int V_ROWS [NV] = '{1, 3, 2, 4};
    localparam int V_LEN  [NV] = '{1, 4, 5, 1};
    localparam int V_BASE [NV] = '{'h100, 'h2000, 'h0, 'h50};
    localparam int V_PITCH[NV] = '{'h40, 'h10, 'h8, 'h100};
    localparam int V_DLY  [NV] = '{0, 0, 2, 1};

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 start;
    logic [NROW_W-1:0]    n_rows;
    logic [ROW_W-1:0]     row_len;
    logic [ADDR_W-1:0]    base_addr;
    logic [ADDR_W-1:0]    row_pitch;
    logic                 rd_req;
    logic                 rd_beat;
    logic [ADDR_W-1:0]    rd_addr;
    logic                 rd_valid;
    logic [N_LANES*W-1:0] rd_data;
    logic                 iss_valid;
    logic [W-1:0]         iss_a, iss_b, iss_c, iss_d, iss_e, iss_k1, iss_k2, iss_js;
    logic                 res_valid;
    logic [W-1:0]         res_data;
    logic                 wr_en;
    logic [ADDR_W-1:0]    wr_addr;
    logic [W-1:0]         wr_data;
    logic                 done;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rowscan_gather #(
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .NROW_W(NROW_W),
        .N_LANES(N_LANES), .N_ROWGAP(N_ROWGAP), .PIPE_LAT(PIPE_LAT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_rows(n_rows), .row_len(row_len),
        .base_addr(base_addr), .row_pitch(row_pitch),
        .rd_req(rd_req), .rd_beat(rd_beat), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .iss_valid(iss_valid), .iss_a(iss_a), .iss_b(iss_b), .iss_c(iss_c),
        .iss_d(iss_d), .iss_e(iss_e), .iss_k1(iss_k1), .iss_k2(iss_k2), .iss_js(iss_js),
        .res_valid(res_valid), .res_data(res_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] lane_word(input logic [ADDR_W-1:0] a, input int beat, input int lane);
        return {a[19:0], 4'(beat), 4'(lane), 4'hC};
    endfunction

    function automatic logic [ADDR_W-1:0] cell_at(input int base, input int pitch, input int r, input int c);
        return ADDR_W'(base + r * pitch + c);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Walk one scan vector, acting as memory and as the datapath
    task automatic run_vector(input int vi);
        int rows = V_ROWS[vi];
        int len  = V_LEN[vi];
        int base = V_BASE[vi];
        int pit  = V_PITCH[vi];
        int dly  = V_DLY[vi];
        int total = rows * len;
        int acc_cell = 0;
        int acc_beat = 0;
        int iss_idx = 0;
        int waitc = 0;
        int gap_low = 0;
        int cyc = 0;
        int drain = 0;
        bit row_end_seen = 0;
        bit need_req = 0;
        bit fin = 0;
        bit dl_v [PIPE_LAT];
        logic [W-1:0] dl_d [PIPE_LAT];
        logic [ADDR_W-1:0] wb_q [$];
        logic [ADDR_W-1:0] exp_a;
        logic [W-1:0] got [8];
        logic [W-1:0] want [8];
        for (int k = 0; k < PIPE_LAT; k++) begin dl_v[k] = 0; dl_d[k] = '0; end

        @(negedge clk);
        n_rows    = NROW_W'(rows);
        row_len   = ROW_W'(len);
        base_addr = ADDR_W'(base);
        row_pitch = ADDR_W'(pit);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;

        while (!(fin && drain > PIPE_LAT + 1) && cyc < 4000) begin
            rd_valid = 1'b0;
            // Issue side: operands due one cycle after beat-1 acceptance
            if (iss_valid) begin
                exp_a = cell_at(base, pit, iss_idx / len, iss_idx % len);
                got = '{iss_a, iss_b, iss_c, iss_d, iss_e, iss_k1, iss_k2, iss_js};
                for (int l = 0; l < 5; l++) want[l] = lane_word(exp_a, 0, l);
                for (int l = 0; l < 3; l++) want[5 + l] = lane_word(exp_a, 1, l);
                for (int f = 0; f < 8; f++)
                    chk(got[f] == want[f], (dly > 0) ? "R5 staged operand" : "R4 operand", got[f], want[f]);
                chk(done == (iss_idx == total - 1), "R9 done with final issue", W'(done), W'(iss_idx == total - 1));
                wb_q.push_back(exp_a);
                iss_idx++;
                if (iss_idx == total) fin = 1;
            end else begin
                chk(!done, "R9 done without issue", W'(done), 0);
            end

            // Datapath model: fixed latency, in order
            res_valid = dl_v[PIPE_LAT-1];
            res_data  = dl_d[PIPE_LAT-1];
            for (int k = PIPE_LAT - 1; k > 0; k--) begin dl_v[k] = dl_v[k-1]; dl_d[k] = dl_d[k-1]; end
            dl_v[0] = iss_valid;
            dl_d[0] = iss_a ^ iss_js ^ W'(iss_idx);

            // Read side
            if (need_req) begin
                chk(rd_req, "R6 no bubble inside row", W'(rd_req), 1);
                need_req = 0;
            end
            if (acc_cell >= total) begin
                chk(!rd_req, "R9 no read after final cell", W'(rd_req), 0);
            end else if (rd_req) begin
                if (row_end_seen) begin
                    chk(gap_low == N_ROWGAP, "R7 row gap length", W'(gap_low), W'(N_ROWGAP));
                    row_end_seen = 0;
                end
                exp_a = cell_at(base, pit, acc_cell / len, acc_cell % len);
                chk(rd_addr == exp_a, "R3 read address", W'(rd_addr), W'(exp_a));
                chk(rd_beat == acc_beat[0], "R3 beat order", W'(rd_beat), W'(acc_beat));
                if (waitc < dly) begin
                    waitc++;
                end else begin
                    rd_valid = 1'b1;
                    for (int l = 0; l < N_LANES; l++) rd_data[l*W +: W] = lane_word(exp_a, acc_beat, l);
                    waitc = 0;
                    if (acc_beat == 0) begin
                        acc_beat = 1;
                    end else begin
                        acc_beat = 0;
                        acc_cell++;
                        if (acc_cell < total) begin
                            if (acc_cell % len == 0) begin row_end_seen = 1; gap_low = 0; end
                            else need_req = 1;
                        end
                    end
                end
            end else begin
                if (row_end_seen) gap_low++;
            end

            // Stray start mid-scan with other settings must be ignored (R2)
            if (vi == 1 && cyc == 6) begin
                start = 1'b1; n_rows = 1; row_len = 1; base_addr = 'hFFF; row_pitch = 'h1;
            end else begin
                start = 1'b0;
            end

            // Write-back port follows res_valid combinationally
            #1;
            if (res_valid) begin
                chk(wr_en, "R8 write strobe", W'(wr_en), 1);
                chk(wb_q.size() > 0 && wr_addr == wb_q[0], "R8 write address order", W'(wr_addr),
                    (wb_q.size() > 0) ? W'(wb_q[0]) : 0);
                chk(wr_data == res_data, "R8 write data", wr_data, res_data);
                if (wb_q.size() > 0) void'(wb_q.pop_front());
            end else begin
                chk(!wr_en, "R8 no write without result", W'(wr_en), 0);
            end

            if (fin) drain++;
            cyc++;
            @(negedge clk);
        end
        res_valid = 1'b0;
        chk(iss_idx == total, "R4 all cells issued", W'(iss_idx), W'(total));
        chk(wb_q.size() == 0, "R8 all results retired", W'(wb_q.size()), 0);
    endtask

    // Watchdog
    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; n_rows = '0; row_len = '0;
        base_addr = '0; row_pitch = '0; rd_valid = 1'b0; rd_data = '0;
        res_valid = 1'b0; res_data = '0;

        // Reset state (R1)
        repeat (3) @(negedge clk);
        chk(!rd_req, "R1 rd_req in reset", W'(rd_req), 0);
        chk(!iss_valid, "R1 iss_valid in reset", W'(iss_valid), 0);
        chk(!done, "R1 done in reset", W'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Zero row length and zero row count are ignored (R2)
        for (int z = 0; z < 2; z++) begin
            n_rows = (z == 0) ? 2 : 0;
            row_len = (z == 0) ? 0 : 3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int q = 0; q < 4; q++) begin
                chk(!rd_req && !iss_valid && !done, "R2 zero-count start ignored",
                    W'({rd_req, iss_valid, done}), 0);
                @(negedge clk);
            end
        end

        // Table-driven scans
        for (int vi = 0; vi < NV; vi++) run_vector(vi);

        // After the last scan the block stays quiet (R2 stray start had no effect)
        repeat (3) begin
            @(negedge clk);
            chk(!rd_req && !iss_valid, "R2 idle after scans", W'({rd_req, iss_valid}), 0);
        end

        summary();
        $finish;
    end

endmodule